// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that works through a chain of fixed-size descriptors held in memory. Each descriptor is eight bytes long. Its first 32-bit word holds a flag byte and a 16-bit byte count. Its second word holds the buffer address. The channel reads each descriptor's two words, decodes the flags, and then moves the described buffer one 32-bit word per accepted memory request. It walks the chain until it finishes a descriptor marked as the final one, and then gives a single-cycle completion pulse.

The direction is fixed by a parameter. A receive channel takes words from a stream input and writes them to memory. A transmit channel reads memory and presents each returned word on a stream output. Software programs the channel through a small write-only configuration port. A transmit channel starts when the low list-address word is written. A receive channel starts only when its run-control word is written with bit 0 set, and it stops when that word is written with bit 0 clear. A receive channel also holds a bytes-per-row value that it passes straight through to the stream side.

The memory port carries one request at a time. A request is held until `mem_gnt` accepts it. Read data returns on a later cycle, marked by `mem_rvalid`.

Top module: `dma_chain_chan`

## Requirements
- R1: After synchronous reset the channel is idle: `busy`, `mem_req`, `done`, `err` and `strm_out_valid` are low, and `row_bytes` is 0.
- R2: A descriptor is fetched as two word reads, first at the descriptor address and then at the descriptor address + 4. In word 0, bits [7:0] are flags and bits [31:16] are the byte count. Word 1 is the buffer address.
- R3: A transmit channel starts fetching at the address written to configuration select 1 (list low). Select 0 (list high) has no effect on the address used. A write to select 2 does not start a transmit channel.
- R4: A receive channel does not start on a list-address write alone. It starts from the stored list low address only when select 2 is written with bit 0 = 1.
- R5: Each accepted data request moves one 32-bit word. The buffer address advances by 4 per word, and the word count is the byte count divided by 4 (count bits [1:0] are ignored).
- R6: Descriptors are contiguous: the next one is fetched at the current address + 8. The chain ends after the descriptor whose flag bit 1 (last) is set.
- R7: A descriptor with a byte count below 4, or with flag bit 5 (transfer) clear, moves no data, and the chain continues.
- R8: A descriptor with flag bit 0 (valid) clear stops the channel with `err` set and no `done` pulse. `err` clears on the next start.
- R9: `done` is high for exactly one cycle. For receive it is the cycle after the final word's write is accepted. For transmit it is the same cycle in which the final word appears on `strm_out_valid`.
- R10: On a receive channel, a select 2 write with bit 0 = 0 returns a busy channel to idle with no `done`. This wins even when it arrives in the same cycle as the final word's acceptance.
- R11: On a receive channel, `row_bytes` follows the value last written to select 3.
- R12: A request not yet granted keeps `mem_req`, `mem_we` and `mem_addr` unchanged in the next cycle.
- R13: Start writes that arrive while the channel is busy are ignored. The running chain continues from its own addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration select: 0 list high, 1 list low, 2 run control, 3 bytes per row |
| cfg_wdata | input | 32 | Configuration write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of request |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| strm_in_data | input | 32 | Receive stream word |
| strm_in_take | output | 1 | Receive stream word consumed this cycle |
| strm_out_valid | output | 1 | Transmit stream word valid |
| strm_out_data | output | 32 | Transmit stream word |
| row_bytes | output | ROW_W | Bytes-per-row pass-through |
| busy | output | 1 | Chain in progress |
| done | output | 1 | One-cycle chain completion pulse |
| err | output | 1 | Invalid descriptor seen |

## Verification
Two things can fall in the same clock edge on a receive channel: the stop write and the acceptance of the chain's final data word. The bench provokes this by letting an eight-word receive descriptor stream with the grant held high. It counts seven accepted words, and then drives the stop write during the eighth acceptance cycle. The result is judged at the ports. No `done` pulse may appear, the channel must go idle without `err`, and the eighth word must still be present in the bench memory because its request was already accepted.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int WORD_W     = 32;
  localparam int LEN_W      = 16;
  localparam int WCNT_W     = LEN_W - 2;
  localparam int DESC_BYTES = 8;
  localparam int WORD_BYTES = WORD_W / 8;

  localparam int FLAG_VALID_BIT = 0;
  localparam int FLAG_LAST_BIT  = 1;
  localparam int FLAG_XFER_BIT  = 5;
  localparam int LEN_LSB        = 16;

  localparam logic [1:0] REG_LIST_HI = 2'd0;
  localparam logic [1:0] REG_LIST_LO = 2'd1;
  localparam logic [1:0] REG_RUN     = 2'd2;
  localparam logic [1:0] REG_ROW     = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR_REQ,
    ST_HDR_WAIT,
    ST_BUF_REQ,
    ST_BUF_WAIT,
    ST_XFER,
    ST_XWAIT
  } chan_state_t;

  typedef struct packed {
    logic              valid;
    logic              last;
    logic              xfer;
    logic [WCNT_W-1:0] words;
  } desc_info_t;
endpackage

// File: rtl/dma_desc_decode.sv
module dma_desc_decode
  import dma_chain_pkg::*;
(
  input  logic [2:0]        flag_bits,
  input  logic [WCNT_W-1:0] wcnt_field,
  output desc_info_t        info
);
  // flag_bits ordering: {transfer, last, valid}
  always_comb begin
    info.valid = flag_bits[0];
    info.last  = flag_bits[1];
    info.xfer  = flag_bits[2];
    info.words = wcnt_field;
  end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WCNT_W-1:0] load_words,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last_word
);
  logic [WCNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      left_q <= '0;
    end else if (load) begin
      addr   <= load_addr;
      left_q <= load_words;
    end else if (step) begin
      addr   <= addr + ADDR_W'(WORD_BYTES);
      left_q <= left_q - WCNT_W'(1);
    end
  end

  assign last_word = (left_q == WCNT_W'(1));
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter bit IS_RX  = 1'b1,
  parameter int ADDR_W = 32,
  parameter int ROW_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] strm_in_data,
  output logic              strm_in_take,
  output logic              strm_out_valid,
  output logic [WORD_W-1:0] strm_out_data,
  output logic [ROW_W-1:0]  row_bytes,
  output logic              busy,
  output logic              done,
  output logic              err
);
  chan_state_t       st_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] start_ptr;
  logic [ADDR_W-1:0] seq_addr;
  desc_info_t        dec_info;
  desc_info_t        desc_q;
  logic              start_req, stop_req;
  logic              seq_last, hdr_done, word_done, desc_end, skip;
  logic              done_q, err_q, out_v_q;
  logic [WORD_W-1:0] out_d_q;

  // Direction-specific start/stop and configuration storage
  generate
    if (IS_RX) begin : g_rx
      logic [ADDR_W-1:0] list_lo_q;
      logic [ROW_W-1:0]  row_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          list_lo_q <= '0;
          row_q     <= '0;
        end else if (cfg_we) begin
          if (cfg_sel == REG_LIST_LO) list_lo_q <= cfg_wdata[ADDR_W-1:0];
          if (cfg_sel == REG_ROW)     row_q     <= cfg_wdata[ROW_W-1:0];
        end
      end
      assign start_req = cfg_we && (cfg_sel == REG_RUN) && cfg_wdata[0];
      assign stop_req  = cfg_we && (cfg_sel == REG_RUN) && !cfg_wdata[0];
      assign start_ptr = list_lo_q;
      assign row_bytes = row_q;
    end else begin : g_tx
      assign start_req = cfg_we && (cfg_sel == REG_LIST_LO);
      assign stop_req  = 1'b0;
      assign start_ptr = cfg_wdata[ADDR_W-1:0];
      assign row_bytes = '0;
    end
  endgenerate

  dma_desc_decode u_decode (
    .flag_bits  ({mem_rdata[FLAG_XFER_BIT], mem_rdata[FLAG_LAST_BIT],
                  mem_rdata[FLAG_VALID_BIT]}),
    .wcnt_field (mem_rdata[LEN_LSB+LEN_W-1:LEN_LSB+2]),
    .info       (dec_info)
  );

  assign hdr_done  = (st_q == ST_BUF_WAIT) && mem_rvalid;
  assign skip      = !desc_q.xfer || (desc_q.words == '0);
  assign word_done = IS_RX ? ((st_q == ST_XFER) && mem_gnt)
                           : ((st_q == ST_XWAIT) && mem_rvalid);
  assign desc_end  = (hdr_done && desc_q.valid && skip) || (word_done && seq_last);

  dma_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .load       (hdr_done),
    .load_addr  (mem_rdata[ADDR_W-1:0]),
    .load_words (desc_q.words),
    .step       (word_done),
    .addr       (seq_addr),
    .last_word  (seq_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      desc_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      out_v_q <= 1'b0;
      out_d_q <= '0;
    end else begin
      done_q  <= 1'b0;
      out_v_q <= 1'b0;
      if (stop_req && (st_q != ST_IDLE)) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE: if (start_req) begin
            st_q  <= ST_HDR_REQ;
            ptr_q <= start_ptr;
            err_q <= 1'b0;
          end
          ST_HDR_REQ:  if (mem_gnt) st_q <= ST_HDR_WAIT;
          ST_HDR_WAIT: if (mem_rvalid) begin
            desc_q <= dec_info;
            st_q   <= ST_BUF_REQ;
          end
          ST_BUF_REQ:  if (mem_gnt) st_q <= ST_BUF_WAIT;
          ST_BUF_WAIT: if (mem_rvalid) begin
            if (!desc_q.valid) begin
              err_q <= 1'b1;
              st_q  <= ST_IDLE;
            end else begin
              st_q <= ST_XFER;
            end
          end
          ST_XFER: if (mem_gnt && !IS_RX) st_q <= ST_XWAIT;
          ST_XWAIT: if (mem_rvalid) begin
            out_v_q <= 1'b1;
            out_d_q <= mem_rdata;
            st_q    <= ST_XFER;
          end
          default: st_q <= ST_IDLE;
        endcase
        // Descriptor completion overrides the per-state next state
        if (desc_end) begin
          if (desc_q.last) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q  <= ST_HDR_REQ;
            ptr_q <= ptr_q + ADDR_W'(DESC_BYTES);
          end
        end
      end
    end
  end

  always_comb begin
    case (st_q)
      ST_HDR_REQ: mem_addr = ptr_q;
      ST_BUF_REQ: mem_addr = ptr_q + ADDR_W'(WORD_BYTES);
      ST_XFER:    mem_addr = seq_addr;
      default:    mem_addr = '0;
    endcase
  end

  assign mem_req        = (st_q == ST_HDR_REQ) || (st_q == ST_BUF_REQ) || (st_q == ST_XFER);
  assign mem_we         = (st_q == ST_XFER) && IS_RX;
  assign mem_wdata      = mem_we ? strm_in_data : '0;
  assign strm_in_take   = mem_we && mem_gnt;
  assign strm_out_valid = out_v_q;
  assign strm_out_data  = out_d_q;
  assign busy           = (st_q != ST_IDLE);
  assign done           = done_q;
  assign err            = err_q;
endmodule

// File: rtl/dma_chain_chan_chk.sv
module dma_chain_chan_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              done,
  input logic              err
);
  assert_req_only_busy_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_data_step_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt && mem_we) |=>
      (!(mem_req && mem_we) || (mem_addr == $past(mem_addr) + ADDR_W'(4))));

  assert_err_no_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !done);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt && !(cfg_we && cfg_sel == 2'd2)) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind dma_chain_chan dma_chain_chan_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_chain_chan_tb_top.sv
module dma_chain_mem_model (
  input  logic        clk,
  input  logic        stall,
  input  logic        req,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        gnt,
  output logic        rvalid,
  output logic [31:0] rdata
);
  logic [31:0] mem [0:255];
  logic        tick;

  initial begin
    tick   = 1'b0;
    rvalid = 1'b0;
    rdata  = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
  end

  assign gnt = !stall || tick;

  always @(posedge clk) begin
    tick   <= !tick;
    rvalid <= req && gnt && !we;
    if (req && gnt && !we) rdata <= mem[addr[9:2]];
    if (req && gnt && we) mem[addr[9:2]] <= wdata;
  end
endmodule

module dma_chain_chan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;
  // each entry: {grant stall enable, byte count}
  localparam logic [16:0] TX_VEC [5] = '{
    {1'b0, 16'd16}, {1'b0, 16'd4}, {1'b1, 16'd20}, {1'b0, 16'd18}, {1'b1, 16'd40}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  int n_tests = 0, n_fail = 0, cyc = 0;

  logic        rx_cfg_we = 1'b0, tx_cfg_we = 1'b0;
  logic [1:0]  rx_cfg_sel = '0, tx_cfg_sel = '0;
  logic [31:0] rx_cfg_wdata = '0, tx_cfg_wdata = '0;
  logic        rx_stall = 1'b0, tx_stall = 1'b0;
  logic        rx_req, rx_we, rx_gnt, rx_rvalid, rx_take, rx_out_v, rx_busy, rx_done, rx_err;
  logic        tx_req, tx_we, tx_gnt, tx_rvalid, tx_take, tx_out_v, tx_busy, tx_done, tx_err;
  logic [31:0] rx_addr, rx_wdata, rx_rdata, rx_out_d;
  logic [31:0] tx_addr, tx_wdata, tx_rdata, tx_out_d;
  logic [15:0] rx_row, tx_row;
  logic [31:0] rx_src = 32'h5A00_0000;
  logic [31:0] tx_in  = '0;

  int tx_nw = 0, tx_ndone = 0, tx_done_cyc = 0, tx_last_out = 0;
  int rx_ntake = 0, rx_ndone = 0, rx_done_cyc = 0, rx_last_take = 0;
  logic [31:0] tx_words [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_chan #(.IS_RX(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(rx_cfg_we), .cfg_sel(rx_cfg_sel), .cfg_wdata(rx_cfg_wdata),
    .mem_req(rx_req), .mem_we(rx_we), .mem_addr(rx_addr), .mem_wdata(rx_wdata),
    .mem_gnt(rx_gnt), .mem_rvalid(rx_rvalid), .mem_rdata(rx_rdata),
    .strm_in_data(rx_src), .strm_in_take(rx_take), .strm_out_valid(rx_out_v),
    .strm_out_data(rx_out_d), .row_bytes(rx_row), .busy(rx_busy), .done(rx_done), .err(rx_err));

  dma_chain_chan #(.IS_RX(1'b0)) dut_tx_i (
    .clk(clk), .rst(rst), .cfg_we(tx_cfg_we), .cfg_sel(tx_cfg_sel), .cfg_wdata(tx_cfg_wdata),
    .mem_req(tx_req), .mem_we(tx_we), .mem_addr(tx_addr), .mem_wdata(tx_wdata),
    .mem_gnt(tx_gnt), .mem_rvalid(tx_rvalid), .mem_rdata(tx_rdata),
    .strm_in_data(tx_in), .strm_in_take(tx_take), .strm_out_valid(tx_out_v),
    .strm_out_data(tx_out_d), .row_bytes(tx_row), .busy(tx_busy), .done(tx_done), .err(tx_err));

  dma_chain_mem_model rx_mem_i (.clk(clk), .stall(rx_stall), .req(rx_req), .we(rx_we),
    .addr(rx_addr), .wdata(rx_wdata), .gnt(rx_gnt), .rvalid(rx_rvalid), .rdata(rx_rdata));
  dma_chain_mem_model tx_mem_i (.clk(clk), .stall(tx_stall), .req(tx_req), .we(tx_we),
    .addr(tx_addr), .wdata(tx_wdata), .gnt(tx_gnt), .rvalid(tx_rvalid), .rdata(tx_rdata));

  always @(posedge clk) if (rx_take) rx_src <= rx_src + 32'd1;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tx_out_v) begin
      if (tx_nw < 64) tx_words[tx_nw] = tx_out_d;
      tx_nw = tx_nw + 1;
      tx_last_out = cyc;
    end
    if (tx_done) begin tx_ndone = tx_ndone + 1; tx_done_cyc = cyc; end
    if (rx_take) begin rx_ntake = rx_ntake + 1; rx_last_take = cyc; end
    if (rx_done) begin rx_ndone = rx_ndone + 1; rx_done_cyc = cyc; end
    if (cyc == WD_CYCLES) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_CYCLES);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tx_cfg(input logic [1:0] sel, input logic [31:0] d);
    tx_cfg_we = 1'b1; tx_cfg_sel = sel; tx_cfg_wdata = d;
    @(negedge clk); tx_cfg_we = 1'b0; #1;
  endtask

  task automatic rx_cfg(input logic [1:0] sel, input logic [31:0] d);
    rx_cfg_we = 1'b1; rx_cfg_sel = sel; rx_cfg_wdata = d;
    @(negedge clk); rx_cfg_we = 1'b0; #1;
  endtask

  task automatic tx_desc(input int a, input logic [7:0] fl, input logic [15:0] len, input logic [31:0] b);
    tx_mem_i.mem[a/4]   = {len, 8'h00, fl};
    tx_mem_i.mem[a/4+1] = b;
  endtask

  task automatic rx_desc(input int a, input logic [7:0] fl, input logic [15:0] len, input logic [31:0] b);
    rx_mem_i.mem[a/4]   = {len, 8'h00, fl};
    rx_mem_i.mem[a/4+1] = b;
  endtask

  task automatic wait_tx_idle();
    @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      if (!tx_busy) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic wait_rx_idle();
    @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      if (!rx_busy) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic tx_clear();
    tx_nw = 0; tx_ndone = 0; tx_done_cyc = -1; tx_last_out = -2;
  endtask

  initial begin
    logic [31:0] src0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 rx busy", 32'(rx_busy), 0);
    chk("R1 tx busy", 32'(tx_busy), 0);
    chk("R1 req", 32'(rx_req | tx_req), 0);
    chk("R1 done/err", 32'({rx_done, tx_done, rx_err, tx_err, tx_out_v}), 0);
    chk("R1 row", 32'(rx_row), 0);

    for (int i = 0; i < 256; i++) tx_mem_i.mem[i] = 32'hC0DE_0000 + 32'(i);

    // R3: high word holds junk, must not matter; run-control write must not start tx
    tx_cfg(2'd0, 32'hFFFF_FFFF);
    tx_desc(0, 8'h23, 16'd8, 32'h200);
    tx_cfg(2'd2, 32'd1);
    repeat (4) @(negedge clk); #1;
    chk("R3 tx not started by run write", 32'(tx_busy), 0);

    // Table-driven transmit runs (R2, R3, R5, R9)
    for (int v = 0; v < 5; v++) begin
      int nexp;
      tx_stall = TX_VEC[v][16];
      tx_desc(0, 8'h23, TX_VEC[v][15:0], 32'h200);
      nexp = int'(TX_VEC[v][15:2]);
      tx_clear();
      tx_cfg(2'd1, 32'h0);
      wait_tx_idle();
      chk("R5 tx word count", 32'(tx_nw), 32'(nexp));
      for (int k = 0; k < nexp; k++)
        chk("R2 R5 tx data", tx_words[k], 32'hC0DE_0000 + 32'(128 + k));
      chk("R9 tx done count", 32'(tx_ndone), 1);
      chk("R9 tx done with last word", 32'(tx_done_cyc), 32'(tx_last_out));
      chk("R3 tx no err", 32'(tx_err), 0);
    end

    // Chain: R6 contiguous walk, R7 zero-length and non-transfer skipped
    tx_stall = 1'b0;
    tx_desc(32'h40, 8'h21, 16'd8, 32'h300);
    tx_desc(32'h48, 8'h21, 16'd0, 32'h000);
    tx_desc(32'h50, 8'h01, 16'd8, 32'h340);
    tx_desc(32'h58, 8'h23, 16'd4, 32'h380);
    tx_clear();
    tx_cfg(2'd1, 32'h40);
    wait_tx_idle();
    chk("R6 R7 chain word count", 32'(tx_nw), 3);
    chk("R6 chain word0", tx_words[0], 32'hC0DE_0000 + 32'd192);
    chk("R6 chain word1", tx_words[1], 32'hC0DE_0000 + 32'd193);
    chk("R7 chain word2 from last desc", tx_words[2], 32'hC0DE_0000 + 32'd224);
    chk("R6 chain done", 32'(tx_ndone), 1);

    // R8 invalid descriptor
    tx_desc(32'h80, 8'h22, 16'd8, 32'h300);
    tx_clear();
    tx_cfg(2'd1, 32'h80);
    wait_tx_idle();
    chk("R8 err set", 32'(tx_err), 1);
    chk("R8 no done", 32'(tx_ndone), 0);
    chk("R8 no data", 32'(tx_nw), 0);
    tx_desc(0, 8'h23, 16'd8, 32'h200);
    tx_clear();
    tx_cfg(2'd1, 32'h0);
    chk("R8 err clears on start", 32'(tx_err), 0);
    wait_tx_idle();
    chk("R8 restart done", 32'(tx_ndone), 1);

    // R13 start write while busy is ignored
    tx_stall = 1'b1;
    tx_desc(0, 8'h23, 16'd40, 32'h200);
    tx_clear();
    tx_cfg(2'd1, 32'h0);
    repeat (6) @(negedge clk); #1;
    tx_cfg(2'd1, 32'h80);
    wait_tx_idle();
    chk("R13 words kept", 32'(tx_nw), 10);
    chk("R13 last data", tx_words[9], 32'hC0DE_0000 + 32'd137);
    chk("R13 no err", 32'(tx_err), 0);
    chk("R13 done", 32'(tx_ndone), 1);

    // Receive: R4 start rules, R11 row pass-through, R5/R9 data and done timing
    rx_desc(0, 8'h23, 16'd16, 32'h100);
    rx_cfg(2'd1, 32'h0);
    repeat (4) @(negedge clk); #1;
    chk("R4 rx idle after list write", 32'(rx_busy), 0);
    rx_cfg(2'd3, 32'd640);
    chk("R11 row bytes", 32'(rx_row), 32'd640);
    src0 = rx_src;
    rx_ndone = 0; rx_ntake = 0;
    rx_cfg(2'd2, 32'd1);
    wait_rx_idle();
    chk("R5 rx take count", 32'(rx_ntake), 4);
    for (int k = 0; k < 4; k++)
      chk("R5 rx written data", rx_mem_i.mem[64 + k], src0 + 32'(k));
    chk("R9 rx done count", 32'(rx_ndone), 1);
    chk("R9 rx done timing", 32'(rx_done_cyc), 32'(rx_last_take + 1));

    // R10 stop lands on final word acceptance
    rx_desc(0, 8'h23, 16'd32, 32'h180);
    src0 = rx_src;
    rx_ndone = 0;
    rx_cfg(2'd2, 32'd1);
    for (int i = 0; i < 200; i++) begin
      if (rx_take) break;
      @(negedge clk);
    end
    repeat (7) @(negedge clk);
    chk("R10 eighth word in flight", 32'(rx_take), 1);
    rx_cfg_we = 1'b1; rx_cfg_sel = 2'd2; rx_cfg_wdata = 32'd0;
    @(negedge clk); rx_cfg_we = 1'b0; #1;
    wait_rx_idle();
    chk("R10 no done on stop", 32'(rx_ndone), 0);
    chk("R10 idle", 32'(rx_busy), 0);
    chk("R10 no err", 32'(rx_err), 0);
    chk("R10 accepted word written", rx_mem_i.mem[96 + 7], src0 + 32'd7);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule